// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block produces the effective address for one pointer that walks a circular buffer in memory. Each operation supplies a two's-complement step, an addressing-mode code and the pointer number the operation names. When circular correction is enabled and the named pointer matches the configured one, the sum of pointer and step is folded back into the buffer window defined by an inclusive lower bound and an upper bound that is the address of the last element.

The fold is based on range comparison, not equality. A forward step is tested for landing above the upper bound, and a backward step for landing below the lower bound. A step larger than one element that jumps past a bound therefore still lands at the right place, with its overshoot kept relative to the opposite bound. The mode code decides whether the output address is the corrected sum or the old pointer, and whether the corrected value is written back to the pointer register, which this block holds.

Top module: `circ_addr_gen`

## Requirements
- R1: After reset, `ptr_q` is 0 and `wb_en` is 0.
- R2: When `ptr_load` is high at a rising edge, `ptr_q` takes `ptr_load_val`. A load takes priority over a write-back in the same cycle.
- R3: With correction active and a step whose top bit is 0, a sum greater than `buf_hi` is reduced by the buffer length L = `buf_hi` − `buf_lo` + ELEM_BYTES. A sum equal to `buf_hi` is kept as it is.
- R4: With correction active and a step whose top bit is 1, a sum less than `buf_lo` is raised by L. A sum equal to `buf_lo` is kept as it is.
- R5: Correction is active only when `mod_enable` is 1 and `step_sel` equals `mod_sel`. Otherwise the corrected value is the plain sum `ptr_q` + `step_mod`, taken modulo 2^AW.
- R6: Mode 2'b00 (pointer plus offset): `ea` is the corrected sum, `wb_en` is 0, and the pointer keeps its value.
- R7: Mode 2'b01 (modify before use): `ea` is the corrected sum, and `wb_en` equals `step_valid`.
- R8: Mode 2'b10 (modify after use): `ea` is the current `ptr_q`, `wb_val` is the corrected sum, and `wb_en` equals `step_valid`.
- R9: Mode 2'b11 (plain indirect): `ea` is `ptr_q`, `wb_en` is 0, and `step_mod` has no effect on `ea` or on the pointer.
- R10: When `wb_en` is 1 and no load occurs, `ptr_q` takes `wb_val` at the next rising edge. With neither a load nor a write-back, `ptr_q` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_load | input | 1 | Load the pointer from `ptr_load_val` |
| ptr_load_val | input | AW | Value to load into the pointer |
| step_valid | input | 1 | An addressing operation is presented this cycle |
| step_mode | input | 2 | Addressing-mode code (see R6 to R9) |
| step_sel | input | SEL_W | Pointer number named by the operation |
| step_mod | input | AW | Two's-complement step |
| mod_enable | input | 1 | Circular correction enable |
| mod_sel | input | SEL_W | Pointer number designated for correction |
| buf_lo | input | AW | Lowest address of the buffer |
| buf_hi | input | AW | Address of the last element of the buffer |
| ea | output | AW | Effective address |
| wb_en | output | 1 | Pointer write-back in this cycle |
| wb_val | output | AW | Corrected pointer value |
| ptr_q | output | AW | Current pointer |

## Verification
The hardest situation to reach from the ports is a step that overshoots a bound by more than one element. A stream of single-element steps only ever lands exactly on a bound, so it never exercises the range comparison. The bench loads the pointer a short distance from each bound and then applies multi-element steps in both directions, so that the sum lands beyond the window on either side. A random phase then steps the pointer through long chains of write-backs, using aligned steps up to one full buffer length in both directions and all mode codes, and compares each result against a model built from the requirements.

// File: rtl/circ_pkg.sv
package circ_pkg;
   typedef enum logic [1:0] {
      CM_OFFSET = 2'b00,
      CM_PRE    = 2'b01,
      CM_POST   = 2'b10,
      CM_DIRECT = 2'b11
   } circ_mode_e;
endpackage

// File: rtl/circ_fold.sv
module circ_fold #(
   parameter int AW         = 16,
   parameter int ELEM_BYTES = 2
) (
   input  logic                 active,
   input  logic [AW-1:0]        base,
   input  logic [AW-1:0]        step,
   input  logic [AW-1:0]        lo,
   input  logic [AW-1:0]        hi,
   output logic [AW+1:0]        result_ext
);
   localparam int EW = AW + 2;

   logic signed [EW-1:0] base_x, step_x, lo_x, hi_x, len_x, sum_x;
   logic                 past_hi, past_lo;

   generate
      if (AW < 4) begin : g_bad_aw
         $error("circ_fold: AW must be at least 4");
      end
      if (ELEM_BYTES < 1 || (ELEM_BYTES & (ELEM_BYTES - 1)) != 0) begin : g_bad_elem
         $error("circ_fold: ELEM_BYTES must be a power of two");
      end
   endgenerate

   always_comb begin
      base_x  = signed'({2'b00, base});
      step_x  = signed'({{2{step[AW-1]}}, step});
      lo_x    = signed'({2'b00, lo});
      hi_x    = signed'({2'b00, hi});
      len_x   = hi_x - lo_x + EW'(ELEM_BYTES);
      sum_x   = base_x + step_x;
      past_hi = !step[AW-1] && (sum_x > hi_x);
      past_lo =  step[AW-1] && (sum_x < lo_x);
      if (active && past_hi)
         result_ext = sum_x - len_x;
      else if (active && past_lo)
         result_ext = sum_x + len_x;
      else
         result_ext = sum_x;
   end
endmodule

// File: rtl/circ_route.sv
module circ_route
   import circ_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic          valid,
   input  circ_mode_e    mode,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] corrected,
   output logic [AW-1:0] ea,
   output logic          wb_en
);
   always_comb begin
      unique case (mode)
         CM_OFFSET: begin ea = corrected; wb_en = 1'b0;  end
         CM_PRE:    begin ea = corrected; wb_en = valid; end
         CM_POST:   begin ea = base;      wb_en = valid; end
         default:   begin ea = base;      wb_en = 1'b0;  end
      endcase
   end
endmodule

// File: rtl/circ_addr_gen.sv
module circ_addr_gen
   import circ_pkg::*;
#(
   parameter int AW         = 16,
   parameter int SEL_W      = 4,
   parameter int ELEM_BYTES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ptr_load,
   input  logic [AW-1:0]    ptr_load_val,
   input  logic             step_valid,
   input  logic [1:0]       step_mode,
   input  logic [SEL_W-1:0] step_sel,
   input  logic [AW-1:0]    step_mod,
   input  logic             mod_enable,
   input  logic [SEL_W-1:0] mod_sel,
   input  logic [AW-1:0]    buf_lo,
   input  logic [AW-1:0]    buf_hi,
   output logic [AW-1:0]    ea,
   output logic             wb_en,
   output logic [AW-1:0]    wb_val,
   output logic [AW-1:0]    ptr_q
);
   localparam int          EW    = AW + 2;
   localparam logic [AW-1:0] ALIGN = AW'(ELEM_BYTES - 1);

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("circ_addr_gen: SEL_W must be at least 1");
      end
   endgenerate

   logic          active;
   logic [EW-1:0] corr_ext;
   logic [1:0]    corr_hi;
   logic [AW-1:0] corr;

   assign active = mod_enable && (step_sel == mod_sel);

   circ_fold #(.AW(AW), .ELEM_BYTES(ELEM_BYTES)) u_fold (
      .active     (active),
      .base       (ptr_q),
      .step       (step_mod),
      .lo         (buf_lo),
      .hi         (buf_hi),
      .result_ext (corr_ext)
   );

   assign {corr_hi, corr} = corr_ext;
   assign wb_val          = corr;

   circ_route #(.AW(AW)) u_route (
      .valid     (step_valid),
      .mode      (circ_mode_e'(step_mode)),
      .base      (ptr_q),
      .corrected (corr),
      .ea        (ea),
      .wb_en     (wb_en)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (ptr_load)
         ptr_q <= ptr_load_val;
      else if (wb_en)
         ptr_q <= wb_val;
   end

   // Window condition under which a fold must land inside the buffer.
   logic signed [EW-1:0] len_chk, mod_chk, mod_abs;
   logic                 in_win;
   always_comb begin
      len_chk = signed'({2'b00, buf_hi}) - signed'({2'b00, buf_lo}) + EW'(ELEM_BYTES);
      mod_chk = signed'({{2{step_mod[AW-1]}}, step_mod});
      mod_abs = mod_chk[EW-1] ? -mod_chk : mod_chk;
      in_win  = (buf_lo <= buf_hi) && (ptr_q >= buf_lo) && (ptr_q <= buf_hi)
             && ((step_mod & ALIGN) == '0) && ((ptr_q & ALIGN) == '0)
             && ((buf_lo & ALIGN) == '0) && ((buf_hi & ALIGN) == '0)
             && (mod_abs <= len_chk);
   end

   assert_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && in_win) |-> (corr_hi == 2'b00 && corr >= buf_lo && corr <= buf_hi));

   assert_plain_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> (corr == AW'(ptr_q + step_mod)));

   assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_load |=> (ptr_q == $past(ptr_load_val)));

   assert_writeback_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_load && wb_en) |=> (ptr_q == $past(wb_val)));

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!ptr_load && !wb_en) |=> $stable(ptr_q));

   assert_post_ea_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_mode == 2'b10) |-> (ea == ptr_q));

   assert_offset_nowb_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_mode == 2'b00) |-> !wb_en);
endmodule

// File: tb/tb_circ_addr_gen.sv
module tb_circ_addr_gen;
   localparam int CLK_P = 10;
   localparam logic [15:0] LO = 16'h1000;
   localparam logic [15:0] HI = 16'h101E;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_load = 1'b0;
   logic [15:0] ptr_load_val = '0;
   logic        step_valid = 1'b0;
   logic [1:0]  step_mode = 2'b11;
   logic [3:0]  step_sel = 4'd3;
   logic [15:0] step_mod = '0;
   logic        mod_enable = 1'b1;
   logic [3:0]  mod_sel = 4'd3;
   logic [15:0] buf_lo = LO;
   logic [15:0] buf_hi = HI;
   logic [15:0] ea, wb_val, ptr_q;
   logic        wb_en;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   circ_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
      .step_valid(step_valid), .step_mode(step_mode), .step_sel(step_sel),
      .step_mod(step_mod), .mod_enable(mod_enable), .mod_sel(mod_sel),
      .buf_lo(buf_lo), .buf_hi(buf_hi), .ea(ea), .wb_en(wb_en),
      .wb_val(wb_val), .ptr_q(ptr_q)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model(input logic [15:0] p, input logic [15:0] m, input bit act);
      int s = int'(p) + int'($signed(m));
      int len = int'(buf_hi) - int'(buf_lo) + 2;
      if (act && !m[15] && s > int'(buf_hi)) s = s - len;
      else if (act && m[15] && s < int'(buf_lo)) s = s + len;
      return s[15:0];
   endfunction

   task automatic load(input logic [15:0] v);
      @(negedge clk);
      ptr_load = 1'b1; ptr_load_val = v; step_valid = 1'b0;
      @(negedge clk);
      ptr_load = 1'b0;
   endtask

   // one operation: check ea/wb in the same cycle, pointer after the edge
   task automatic op(input logic [1:0] md, input logic [15:0] m, input logic [3:0] sel, input string tag);
      logic [15:0] p0, cor, exp_ea, exp_ptr;
      bit act, exp_wb;
      @(negedge clk);
      step_valid = 1'b1; step_mode = md; step_mod = m; step_sel = sel;
      #1;
      p0  = ptr_q;
      act = mod_enable && (sel == mod_sel);
      cor = model(p0, m, act);
      exp_wb  = (md == 2'b01) || (md == 2'b10);
      exp_ea  = (md == 2'b00 || md == 2'b01) ? cor : p0;
      exp_ptr = exp_wb ? cor : p0;
      chk(ea == exp_ea, {tag, " ea"}, ea, exp_ea);
      chk(wb_en == exp_wb, {tag, " wb_en"}, 16'(wb_en), 16'(exp_wb));
      if (exp_wb) chk(wb_val == cor, {tag, " wb_val"}, wb_val, cor);
      @(negedge clk);
      step_valid = 1'b0; step_mode = 2'b11;
      chk(ptr_q == exp_ptr, {tag, " ptr"}, ptr_q, exp_ptr);
   endtask

   task automatic t_reset;
      @(negedge clk); #1;
      chk(ptr_q == 16'h0, "R1 reset ptr", ptr_q, 16'h0);
      chk(!wb_en, "R1 reset wb_en", 16'(wb_en), 16'h0);
   endtask

   task automatic t_load;
      load(16'h1234);
      chk(ptr_q == 16'h1234, "R2 load", ptr_q, 16'h1234);
      @(negedge clk);
      ptr_load = 1'b1; ptr_load_val = 16'h1008;
      step_valid = 1'b1; step_mode = 2'b01; step_mod = 16'h0004;
      @(negedge clk);
      ptr_load = 1'b0; step_valid = 1'b0; step_mode = 2'b11;
      chk(ptr_q == 16'h1008, "R2 load over writeback", ptr_q, 16'h1008);
   endtask

   task automatic t_upper;
      load(16'h101C);
      op(2'b01, 16'h0002, 4'd3, "R3 exact upper");
      chk(ptr_q == 16'h101E, "R3 lands on hi", ptr_q, 16'h101E);
      load(16'h101C);
      op(2'b01, 16'h0006, 4'd3, "R3 overshoot upper");
      chk(ptr_q == 16'h1002, "R3 fold to 1002", ptr_q, 16'h1002);
      op(2'b01, 16'h0020, 4'd3, "R3 full length step");
   endtask

   task automatic t_lower;
      load(16'h1002);
      op(2'b01, 16'hFFFE, 4'd3, "R4 exact lower");
      chk(ptr_q == 16'h1000, "R4 lands on lo", ptr_q, 16'h1000);
      load(16'h1002);
      op(2'b01, 16'hFFFA, 4'd3, "R4 overshoot lower");
      chk(ptr_q == 16'h101C, "R4 fold to 101C", ptr_q, 16'h101C);
   endtask

   task automatic t_inactive;
      load(16'h101C);
      op(2'b01, 16'h0006, 4'd5, "R5 sel mismatch");
      chk(ptr_q == 16'h1022, "R5 plain sum", ptr_q, 16'h1022);
      mod_enable = 1'b0;
      load(16'h1002);
      op(2'b01, 16'hFFFA, 4'd3, "R5 disabled");
      chk(ptr_q == 16'h0FFC, "R5 plain diff", ptr_q, 16'h0FFC);
      mod_enable = 1'b1;
   endtask

   task automatic t_offset;
      load(16'h101C);
      op(2'b00, 16'h0006, 4'd3, "R6 offset");
      chk(ptr_q == 16'h101C, "R6 ptr unchanged", ptr_q, 16'h101C);
   endtask

   task automatic t_post;
      load(16'h101C);
      op(2'b10, 16'h0004, 4'd3, "R8 post");
      chk(ptr_q == 16'h1000, "R8 post writeback", ptr_q, 16'h1000);
   endtask

   task automatic t_direct;
      load(16'h1010);
      op(2'b11, 16'h0040, 4'd3, "R9 direct");
      chk(ptr_q == 16'h1010, "R9 ptr unchanged", ptr_q, 16'h1010);
   endtask

   task automatic t_random;
      load(16'h100A);
      for (int i = 0; i < 300; i++) begin
         logic [1:0] md = 2'($urandom_range(0, 3));
         int st = 2 * $urandom_range(0, 32) - 32;
         op(md, 16'(st), ($urandom_range(0, 7) == 0) ? 4'd6 : 4'd3, "R7 R10 random");
         if (ptr_q < LO || ptr_q > HI) load(16'h1000 + 16'(2 * $urandom_range(0, 15)));
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            t_reset();
            t_load();
            t_upper();
            t_lower();
            t_inactive();
            t_offset();
            t_post();
            t_direct();
            t_random();
         end
         begin
            repeat (50000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
         end
      join_any
      disable fork;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule